// File: doc/BRIEF.md
# Single-Level Interrupt Entry Sequencer

This block sits beside a processor's program-counter and register-file logic and decides when execution is diverted into the interrupt service routine. It watches a timer rollover request and a vector of external edge-pending bits. When interrupts are unmasked and any enabled source is active, it saves the current program counter into a one-entry stack and three working registers (file-select, status and accumulator) into shadow copies. It then forces the program counter to address 0 and masks every further request. All sources share that one vector and none outranks another; the service routine polls the pending bits to find the cause.

A return command restores the stacked program counter and the three shadows and unmasks interrupts. If any external pending bit is still set at that moment, the sequencer does not resume the interrupted program. It sends execution straight back to the vector and keeps the original context saved. A second return command does the same and also emits a one-cycle pulse that carries the accumulator value to the timer's add port, so the service routine can set the time to the next rollover. A wakeup input, raised when an edge brings the core out of sleep, sends the program counter to the highest program address, the same as after reset.

Every output is registered and changes on the clock edge after the input that causes it.

Top module: `isr_sequencer`

## Requirements
- R1: After reset, `pc_load_o`, `regs_load_o`, `tmr_add_o` and `masked_o` are all 0.
- R2: When `masked_o` is 0 and a request is active, the next edge raises `pc_load_o` for one cycle with `pc_o` = 0 and sets `masked_o` to 1. A request is active when any bit of `ext_pend_i` is set, or when `tmr_en_i` is 1 and a timer request is pending.
- R3: On entry, `pc_i` is saved. A later return with no external bit pending drives `pc_o` to that saved value with `pc_load_o` = 1.
- R4: On entry, `fsr_i`, `stat_i` and `w_i` are saved. Every return raises `regs_load_o` for one cycle and drives those saved values on `fsr_o`, `stat_o` and `w_o`.
- R5: While `masked_o` is 1, new timer or external requests cause no program-counter load. While `masked_o` is 0, `ret_i` and `ret_add_i` are ignored, so no output pulse occurs.
- R6: A return with `ext_pend_i` all zero clears `masked_o` on the next edge.
- R7: A return through `ret_add_i` also raises `tmr_add_o` for one cycle, with `tmr_add_val_o` equal to `w_i` sampled with the command. A return through `ret_i` leaves `tmr_add_o` at 0.
- R8: A return while any bit of `ext_pend_i` is set loads `pc_o` = 0 and keeps `masked_o` at 1. The saved program counter stays unchanged for the next return.
- R9: A one-cycle `tmr_req_i` pulse that arrives while interrupts are masked or `tmr_en_i` is 0 is held. It causes entry as soon as interrupts are unmasked and the timer is enabled. Entry clears the held request.
- R10: `wake_i` wins over every other input. On the next edge it loads `pc_o` with all ones (0x7FF for 11 bits), clears `masked_o` and discards a held timer request.
- R11: Each external pending bit alone is enough to cause entry, and the vector is the same whichever bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_req_i | input | 1 | Timer rollover request pulse |
| tmr_en_i | input | 1 | Timer interrupt enable |
| ext_pend_i | input | EXT_W (8) | External edge-pending bits |
| pc_i | input | PC_W (11) | Address to resume at after service |
| fsr_i | input | DW (8) | Current file-select register |
| stat_i | input | DW (8) | Current status register |
| w_i | input | DW (8) | Current accumulator |
| ret_i | input | 1 | Plain return command |
| ret_add_i | input | 1 | Return command that also adds W to the timer |
| wake_i | input | 1 | Wakeup from sleep by an edge |
| pc_load_o | output | 1 | Program-counter load strobe |
| pc_o | output | PC_W (11) | Program-counter load value |
| regs_load_o | output | 1 | Register restore strobe |
| fsr_o | output | DW (8) | Restored file-select register |
| stat_o | output | DW (8) | Restored status register |
| w_o | output | DW (8) | Restored accumulator |
| tmr_add_o | output | 1 | Timer add strobe |
| tmr_add_val_o | output | DW (8) | Value to add to the timer |
| masked_o | output | 1 | Interrupts masked (service in progress) |

## Verification
The assertions check several rules on every cycle. Each entry loads vector 0 and saves the program counter seen with the request. A vector load while masked only ever follows a return command. A timer-add strobe only follows an add-return taken while masked. A wakeup always lands on the top address. A pulse left unaccepted stays held. Only the bench scenarios can show that the values restored are the ones saved several cycles earlier, that a held timer request fires after an unmask, and that a re-entry keeps the original stacked address for the final return. The bench also shows that every external bit, taken alone, reaches the same vector.

// File: rtl/isr_seq_pkg.sv
package isr_seq_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_WAKE   = 2'd1,
        ACT_ENTER  = 2'd2,
        ACT_RETURN = 2'd3
    } seq_act_e;
endpackage

// File: rtl/isr_req_gate.sv
module isr_req_gate #(
    parameter int EXT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_req_i,
    input  logic             tmr_en_i,
    input  logic [EXT_W-1:0] ext_pend_i,
    input  logic             accept_i,
    output logic             tmr_fire_o,
    output logic             ext_any_o
);
    typedef struct packed {
        logic hold;
    } gate_t;

    gate_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        r_d.hold   = (r_q.hold | tmr_req_i) & ~accept_i;
        tmr_fire_o = (r_q.hold | tmr_req_i) & tmr_en_i;
        ext_any_o  = |ext_pend_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_TMR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tmr_req_i) && !$past(accept_i)) |-> r_q.hold); // R9
endmodule

// File: rtl/isr_ctx_store.sv
module isr_ctx_store #(
    parameter int PC_W = 11,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [DW-1:0]   fsr_i,
    input  logic [DW-1:0]   stat_i,
    input  logic [DW-1:0]   w_i,
    output logic [PC_W-1:0] stk_pc_o,
    output logic [DW-1:0]   sh_fsr_o,
    output logic [DW-1:0]   sh_stat_o,
    output logic [DW-1:0]   sh_w_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [DW-1:0]   fsr;
        logic [DW-1:0]   stat;
        logic [DW-1:0]   w;
    } ctx_t;

    ctx_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (save_i) begin
            c_d.pc   = pc_i;
            c_d.fsr  = fsr_i;
            c_d.stat = stat_i;
            c_d.w    = w_i;
        end
        stk_pc_o  = c_q.pc;
        sh_fsr_o  = c_q.fsr;
        sh_stat_o = c_q.stat;
        sh_w_o    = c_q.w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    AST_SAVE_TAKES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(save_i) |-> (c_q.pc == $past(pc_i))); // R3
endmodule

// File: rtl/isr_sequencer.sv
module isr_sequencer #(
    parameter int PC_W  = 11,
    parameter int DW    = 8,
    parameter int EXT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_req_i,
    input  logic             tmr_en_i,
    input  logic [EXT_W-1:0] ext_pend_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [DW-1:0]    fsr_i,
    input  logic [DW-1:0]    stat_i,
    input  logic [DW-1:0]    w_i,
    input  logic             ret_i,
    input  logic             ret_add_i,
    input  logic             wake_i,
    output logic             pc_load_o,
    output logic [PC_W-1:0]  pc_o,
    output logic             regs_load_o,
    output logic [DW-1:0]    fsr_o,
    output logic [DW-1:0]    stat_o,
    output logic [DW-1:0]    w_o,
    output logic             tmr_add_o,
    output logic [DW-1:0]    tmr_add_val_o,
    output logic             masked_o
);
    import isr_seq_pkg::*;

    localparam logic [PC_W-1:0] VEC_ADDR  = '0;
    localparam logic [PC_W-1:0] WAKE_ADDR = '1;

    typedef struct packed {
        logic            in_isr;
        logic            pc_load;
        logic [PC_W-1:0] pc;
        logic            regs_load;
        logic [DW-1:0]   fsr;
        logic [DW-1:0]   stat;
        logic [DW-1:0]   w;
        logic            add;
        logic [DW-1:0]   add_val;
    } seq_t;

    seq_t s_q, s_d;
    seq_act_e act;

    logic            tmr_fire, ext_any, accept;
    logic [PC_W-1:0] stk_pc;
    logic [DW-1:0]   sh_fsr, sh_stat, sh_w;

    assign accept = (act == ACT_ENTER) || (act == ACT_WAKE);

    isr_req_gate #(.EXT_W(EXT_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_req_i  (tmr_req_i),
        .tmr_en_i   (tmr_en_i),
        .ext_pend_i (ext_pend_i),
        .accept_i   (accept),
        .tmr_fire_o (tmr_fire),
        .ext_any_o  (ext_any)
    );

    isr_ctx_store #(.PC_W(PC_W), .DW(DW)) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .save_i    (act == ACT_ENTER),
        .pc_i      (pc_i),
        .fsr_i     (fsr_i),
        .stat_i    (stat_i),
        .w_i       (w_i),
        .stk_pc_o  (stk_pc),
        .sh_fsr_o  (sh_fsr),
        .sh_stat_o (sh_stat),
        .sh_w_o    (sh_w)
    );

    // Action select: wakeup first, then entry when unmasked, then return when masked.
    always_comb begin
        if (wake_i)
            act = ACT_WAKE;
        else if (!s_q.in_isr && (tmr_fire || ext_any))
            act = ACT_ENTER;
        else if (s_q.in_isr && (ret_i || ret_add_i))
            act = ACT_RETURN;
        else
            act = ACT_IDLE;
    end

    always_comb begin
        s_d           = s_q;
        s_d.pc_load   = 1'b0;
        s_d.regs_load = 1'b0;
        s_d.add       = 1'b0;
        unique case (act)
            ACT_WAKE: begin
                s_d.pc_load = 1'b1;
                s_d.pc      = WAKE_ADDR;
                s_d.in_isr  = 1'b0;
            end
            ACT_ENTER: begin
                s_d.pc_load = 1'b1;
                s_d.pc      = VEC_ADDR;
                s_d.in_isr  = 1'b1;
            end
            ACT_RETURN: begin
                s_d.pc_load   = 1'b1;
                s_d.regs_load = 1'b1;
                s_d.fsr       = sh_fsr;
                s_d.stat      = sh_stat;
                s_d.w         = sh_w;
                s_d.add       = ret_add_i;
                s_d.add_val   = w_i;
                if (ext_any) begin
                    s_d.pc     = VEC_ADDR;
                    s_d.in_isr = 1'b1;
                end else begin
                    s_d.pc     = stk_pc;
                    s_d.in_isr = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pc_load_o     = s_q.pc_load;
    assign pc_o          = s_q.pc;
    assign regs_load_o   = s_q.regs_load;
    assign fsr_o         = s_q.fsr;
    assign stat_o        = s_q.stat;
    assign w_o           = s_q.w;
    assign tmr_add_o     = s_q.add;
    assign tmr_add_val_o = s_q.add_val;
    assign masked_o      = s_q.in_isr;

    AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.in_isr) |-> (s_q.pc_load && s_q.pc == VEC_ADDR)); // R2
    AST_MASKED_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.in_isr && $past(s_q.in_isr) && s_q.pc_load) |-> $past(ret_i || ret_add_i)); // R5
    AST_ADD_FROM_RET: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.add |-> $past(ret_add_i && s_q.in_isr)); // R7
    AST_WAKE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wake_i) |-> (s_q.pc_load && s_q.pc == WAKE_ADDR && !s_q.in_isr)); // R10
    AST_UNMASK_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(s_q.in_isr) && !$past(wake_i)) |-> s_q.regs_load); // R6
endmodule

// File: tb/isr_sequencer_test.sv
module isr_sequencer_test;
    localparam int PC_W = 11, DW = 8, EXT_W = 8;

    logic clk = 0, rst_n = 0;
    logic tmr_req = 0, tmr_en = 0, ret = 0, ret_add = 0, wake = 0;
    logic [EXT_W-1:0] ext = '0;
    logic [PC_W-1:0] pc_in = '0;
    logic [DW-1:0] fsr = '0, stat = '0, w = '0;
    logic pc_load, regs_load, tadd, masked;
    logic [PC_W-1:0] pc_out;
    logic [DW-1:0] fsr_o, stat_o, w_o, tadd_val;

    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    isr_sequencer #(.PC_W(PC_W), .DW(DW), .EXT_W(EXT_W)) uut (
        .clk(clk), .rst_n(rst_n), .tmr_req_i(tmr_req), .tmr_en_i(tmr_en),
        .ext_pend_i(ext), .pc_i(pc_in), .fsr_i(fsr), .stat_i(stat), .w_i(w),
        .ret_i(ret), .ret_add_i(ret_add), .wake_i(wake),
        .pc_load_o(pc_load), .pc_o(pc_out), .regs_load_o(regs_load),
        .fsr_o(fsr_o), .stat_o(stat_o), .w_o(w_o), .tmr_add_o(tadd),
        .tmr_add_val_o(tadd_val), .masked_o(masked)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        chk("R1 pc_load", pc_load, 0);
        chk("R1 masked", masked, 0);
        chk("R1 tadd", tadd, 0);
        chk("R1 regs_load", regs_load, 0);
        rst_n = 1;
        tick();

        // R5: return while unmasked is ignored
        ret = 1; tick(); ret = 0;
        chk("R5 ret unmasked pc_load", pc_load, 0);
        chk("R5 ret unmasked regs_load", regs_load, 0);

        // R11 sweep: each external bit alone enters; context round trip (R3 R4 R6)
        for (int i = 0; i < EXT_W; i++) begin
            logic [PC_W-1:0] epc;
            logic [DW-1:0] ef, es, ew;
            epc = PC_W'(11'h0A3 + i * 173);
            ef = DW'(i * 17 + 3); es = DW'(8'hC0 ^ i); ew = DW'(255 - i * 9);
            pc_in = epc; fsr = ef; stat = es; w = ew;
            ext = EXT_W'(1) << i;
            tick();
            chk("R11 entry pc_load", pc_load, 1);
            chk("R2 entry pc", pc_out, 0);
            chk("R2 masked", masked, 1);
            pc_in = '1; fsr = 8'h55; stat = 8'hAA; w = 8'h11;
            // R5: request still asserted while masked: no new load
            tick();
            chk("R5 masked no load", pc_load, 0);
            ext = '0;
            tick();
            ret = 1; tick(); ret = 0;
            chk("R3 restore pc", pc_out, int'(epc));
            chk("R3 pc_load", pc_load, 1);
            chk("R4 regs_load", regs_load, 1);
            chk("R4 fsr", fsr_o, int'(ef));
            chk("R4 stat", stat_o, int'(es));
            chk("R4 w", w_o, int'(ew));
            chk("R7 no add on plain ret", tadd, 0);
            chk("R6 unmasked", masked, 0);
            tick();
            chk("R6 stays idle", pc_load, 0);
        end

        // R9: timer pulse while disabled is held, fires when enabled
        pc_in = 11'h321; fsr = 8'h01; stat = 8'h02; w = 8'h03;
        tmr_req = 1; tick(); tmr_req = 0;
        chk("R9 disabled no entry", pc_load, 0);
        tick(); tick();
        chk("R9 still idle", masked, 0);
        tmr_en = 1; tick();
        chk("R9 held fires", pc_load, 1);
        chk("R9 vector", pc_out, 0);
        // pulse while masked: held
        tmr_req = 1; tick(); tmr_req = 0;
        chk("R5 timer masked no load", pc_load, 0);
        pc_in = 11'h444;
        // R7: add-return
        w = 8'hEC; ret_add = 1; tick(); ret_add = 0;
        chk("R7 add strobe", tadd, 1);
        chk("R7 add value", tadd_val, 8'hEC);
        chk("R3 timer ret pc", pc_out, 11'h321);
        chk("R4 timer ret w", w_o, 8'h03);
        tick();
        chk("R7 add one cycle", tadd, 0);
        chk("R9 held re-entry", pc_load, 1);
        chk("R9 re-entry vector", pc_out, 0);
        ret = 1; tick(); ret = 0;
        chk("R9 re-entry return pc", pc_out, 11'h444);
        tick();
        chk("R9 hold cleared", pc_load, 0);
        tick();
        chk("R9 hold cleared masked", masked, 0);
        tmr_en = 0;

        // R8: return with ext still pending re-enters, keeps stack
        pc_in = 11'h5A5; fsr = 8'h21; stat = 8'h22; w = 8'h23;
        ext = 8'h40; tick();
        chk("R2 ext entry", masked, 1);
        pc_in = 11'h000;
        w = 8'h77; ret_add = 1; tick(); ret_add = 0;
        chk("R8 re-vector pc", pc_out, 0);
        chk("R8 pc_load", pc_load, 1);
        chk("R8 still masked", masked, 1);
        chk("R8 regs restored w", w_o, 8'h23);
        chk("R7 add on re-entry", tadd_val, 8'h77);
        ext = '0; tick();
        ret = 1; tick(); ret = 0;
        chk("R8 stack kept", pc_out, 11'h5A5);
        chk("R8 unmasked after", masked, 0);

        // R10: wake inside service and with held timer
        ext = 8'h01; tick(); ext = '0;
        chk("R2 enter before wake", masked, 1);
        tmr_req = 1; tick(); tmr_req = 0;
        wake = 1; ret = 1; tick(); wake = 0; ret = 0;
        chk("R10 wake pc", pc_out, 11'h7FF);
        chk("R10 wake load", pc_load, 1);
        chk("R10 unmask", masked, 0);
        chk("R10 no restore", regs_load, 0);
        tmr_en = 1; tick();
        chk("R10 held timer discarded", pc_load, 0);
        chk("R10 held timer discarded masked", masked, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule